// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block wraps a small single-ported word memory and serves atomic operations from one request interface. A requester presents an opcode, a word address, an expected value and a new (or increment) value with a valid/ready handshake. The unit performs the whole read, compare and write as one locked sequence and answers with a success flag, an error flag and the prior contents. No other request can be accepted between the compare and the write, so every operation is indivisible.

Six operations are provided. There are plain read and write, a compare-and-swap that reports only whether it succeeded, and a compare-and-swap that always returns the prior word. There is also fetch-and-add, and a double-width compare-and-swap that treats an even/odd word pair as one unit. That last one suits a pointer plus a version tag, where an equal pointer with a stale tag must fail. A double-width request at an odd address is rejected with an error and never split into partial accesses.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After a synchronous active-low reset every memory word reads as zero, `rsp_valid` is low and `req_ready` is high.
- R2: Opcode 0 (read) returns the addressed word in the low half of `rsp_old` with `rsp_ok`=1 and no memory change. Opcode 1 (write) stores the low half of `req_new`, returns the prior word and sets `rsp_ok`=1.
- R3: Opcode 2 (flag compare-and-swap) stores the low half of `req_new` only if the word equals the low half of `req_cmp`. `rsp_ok` gives the outcome and `rsp_old` is zero. On a mismatch memory is unchanged.
- R4: Opcode 3 (valued compare-and-swap) has the same write rule as R3 but always returns the word as it was before the operation.
- R5: Opcode 4 (fetch-and-add) stores the word plus the low half of `req_new`, modulo 2^DATA_W, and returns the prior word with `rsp_ok`=1.
- R6: Opcode 5 (double compare-and-swap) at an even address compares {word at addr+1, word at addr} with `req_cmp` (high half, low half). It writes `req_new` into both words only if both halves match and fails if either differs. It returns both prior words in `rsp_old`.
- R7: Opcode 5 at an odd address returns `rsp_err`=1, `rsp_ok`=0, `rsp_old`=0 and leaves memory unchanged.
- R8: Opcodes 6 and 7 return `rsp_err`=1, `rsp_ok`=0 and leave memory unchanged.
- R9: A request accepted at one clock edge has its response and its write at the second following edge. `req_ready` is low in between, so the next request sees the completed write.
- R10: For single-word operations the high half of `rsp_old` is zero, and `rsp_ok` and `rsp_err` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Word address |
| req_cmp | input | 2*DATA_W | Expected value (low half for single-word ops) |
| req_new | input | 2*DATA_W | New value or increment (low half for single-word ops) |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_ok | output | 1 | Operation succeeded |
| rsp_err | output | 1 | Misaligned or unknown request, nothing written |
| rsp_old | output | 2*DATA_W | Prior contents |

## Verification
The bench goes after the double-width swap where the pointer matches but the tag differs, and the case where the tag matches but the pointer differs. A design comparing only one half would wrongly succeed and overwrite the pair. It drives a double-width request at an odd address: a design that split it would corrupt the neighbouring pair instead of returning an error. Fetch-and-add is run across the word boundary to catch a carry leaking into the result. Each failing compare-and-swap is followed by a read, which exposes any stray write on a mismatch.

// File: rtl/rmw_pkg.sv
// Shared opcode type for the atomic read-modify-write unit.
package rmw_pkg;
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_CASB  = 3'd2,
        OP_CASV  = 3'd3,
        OP_FADD  = 3'd4,
        OP_DCAS  = 3'd5
    } rmw_op_e;
endpackage

// File: rtl/rmw_store.sv
// Word memory organised as rows of two words with per-half write enables.
// Assumes one access per cycle (single port, full row wide); sync active-low reset clears all rows.
module rmw_store #(
    parameter int DATA_W = 32,
    parameter int ROWS   = 32,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    row_idx,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [2*DATA_W-1:0] wr_row,
    output logic [2*DATA_W-1:0] rd_row
);
    logic [2*DATA_W-1:0] mem_q [ROWS];

    // Read the addressed row combinationally.
    assign rd_row = mem_q[row_idx];

    // Clear on reset, else update the enabled halves of the addressed row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) mem_q[i] <= '0;
        end else begin
            if (wr_lo) mem_q[row_idx][DATA_W-1:0]        <= wr_row[DATA_W-1:0];
            if (wr_hi) mem_q[row_idx][2*DATA_W-1:DATA_W] <= wr_row[2*DATA_W-1:DATA_W];
        end
    end

    // R5
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (mem_q[$past(row_idx)][DATA_W-1:0] == $past(wr_row[DATA_W-1:0])));
    // R6
    hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (mem_q[$past(row_idx)][2*DATA_W-1:DATA_W] == $past(wr_row[2*DATA_W-1:DATA_W])));
endmodule

// File: rtl/rmw_alu.sv
// Combinational compare/modify stage: from the current row and the latched
// request it works out write enables, write data and the response fields.
// Assumes the row holds words {addr|1, addr&~1}.
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]          op,
    input  logic                addr_lsb,
    input  logic [2*DATA_W-1:0] cur_row,
    input  logic [2*DATA_W-1:0] cmp_val,
    input  logic [2*DATA_W-1:0] new_val,
    output logic                wr_lo,
    output logic                wr_hi,
    output logic [2*DATA_W-1:0] wr_row,
    output logic                ok,
    output logic                err,
    output logic [2*DATA_W-1:0] old_val
);
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_d;
    logic              word_we;
    logic              word_match;

    assign word_q     = addr_lsb ? cur_row[2*DATA_W-1:DATA_W] : cur_row[DATA_W-1:0];
    assign word_match = (word_q == cmp_val[DATA_W-1:0]);

    // Decode the operation into a single-word or pair update and a response.
    always_comb begin
        word_we = 1'b0;
        word_d  = new_val[DATA_W-1:0];
        wr_lo   = 1'b0;
        wr_hi   = 1'b0;
        wr_row  = {word_d, word_d};
        ok      = 1'b0;
        err     = 1'b0;
        old_val = '0;
        case (op)
            OP_READ: begin
                ok      = 1'b1;
                old_val = {{DATA_W{1'b0}}, word_q};
            end
            OP_WRITE: begin
                word_we = 1'b1;
                ok      = 1'b1;
                old_val = {{DATA_W{1'b0}}, word_q};
            end
            OP_CASB: begin
                word_we = word_match;
                ok      = word_match;
            end
            OP_CASV: begin
                word_we = word_match;
                ok      = word_match;
                old_val = {{DATA_W{1'b0}}, word_q};
            end
            OP_FADD: begin
                word_we = 1'b1;
                word_d  = word_q + new_val[DATA_W-1:0];
                ok      = 1'b1;
                old_val = {{DATA_W{1'b0}}, word_q};
            end
            OP_DCAS: begin
                if (addr_lsb) begin
                    err = 1'b1;
                end else begin
                    ok      = (cur_row == cmp_val);
                    old_val = cur_row;
                end
            end
            default: err = 1'b1;
        endcase
        if (op == OP_DCAS) begin
            wr_row = new_val;
            wr_lo  = ok;
            wr_hi  = ok;
        end else begin
            wr_row = {word_d, word_d};
            wr_lo  = word_we && !addr_lsb;
            wr_hi  = word_we && addr_lsb;
        end
    end
endmodule

// File: rtl/rmw_seq.sv
// Request sequencer: accepts one request when idle, holds it for one locked
// execute cycle, then registers the response. Assumes the store writes at
// the same edge the response is registered.
module rmw_seq #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [2:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*DATA_W-1:0] req_cmp,
    input  logic [2*DATA_W-1:0] req_new,
    output logic                exec,
    output logic [2:0]          cur_op,
    output logic [ADDR_W-1:0]   cur_addr,
    output logic [2*DATA_W-1:0] cur_cmp,
    output logic [2*DATA_W-1:0] cur_new,
    input  logic                res_ok,
    input  logic                res_err,
    input  logic [2*DATA_W-1:0] res_old,
    output logic                rsp_valid,
    output logic                rsp_ok,
    output logic                rsp_err,
    output logic [2*DATA_W-1:0] rsp_old
);
    logic busy_q;
    logic accept;

    assign req_ready = !busy_q;
    assign accept    = req_valid && req_ready;
    assign exec      = busy_q;

    // Track the lock: set on acceptance, released after the execute cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (accept) busy_q <= 1'b1;
        else             busy_q <= 1'b0;
    end

    // Capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op   <= '0;
            cur_addr <= '0;
            cur_cmp  <= '0;
            cur_new  <= '0;
        end else if (accept) begin
            cur_op   <= req_op;
            cur_addr <= req_addr;
            cur_cmp  <= req_cmp;
            cur_new  <= req_new;
        end
    end

    // Register the response at the end of the execute cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_old   <= '0;
        end else begin
            rsp_valid <= busy_q;
            rsp_ok    <= busy_q && res_ok;
            rsp_err   <= busy_q && res_err;
            rsp_old   <= busy_q ? res_old : '0;
        end
    end

    // R9
    lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 rsp_valid);
    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_ok && rsp_err));
    // R7
    err_old_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_old == '0));
endmodule

// File: rtl/atomic_rmw_unit.sv
// Atomic read-modify-write memory unit: top level joining sequencer,
// compare/modify stage and two-word-row store. Assumes a power-of-two depth
// of at least two words.
module atomic_rmw_unit #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [2:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*DATA_W-1:0] req_cmp,
    input  logic [2*DATA_W-1:0] req_new,
    output logic                rsp_valid,
    output logic                rsp_ok,
    output logic                rsp_err,
    output logic [2*DATA_W-1:0] rsp_old
);
    localparam int ROWS = (1 << ADDR_W) / 2;

    logic                exec;
    logic [2:0]          cur_op;
    logic [ADDR_W-1:0]   cur_addr;
    logic [2*DATA_W-1:0] cur_cmp, cur_new, cur_row, wr_row, res_old;
    logic                a_wr_lo, a_wr_hi, res_ok, res_err;

    rmw_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_cmp(req_cmp), .req_new(req_new),
        .exec(exec), .cur_op(cur_op), .cur_addr(cur_addr),
        .cur_cmp(cur_cmp), .cur_new(cur_new),
        .res_ok(res_ok), .res_err(res_err), .res_old(res_old),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err), .rsp_old(rsp_old)
    );

    rmw_alu #(.DATA_W(DATA_W)) u_alu (
        .op(cur_op), .addr_lsb(cur_addr[0]), .cur_row(cur_row),
        .cmp_val(cur_cmp), .new_val(cur_new),
        .wr_lo(a_wr_lo), .wr_hi(a_wr_hi), .wr_row(wr_row),
        .ok(res_ok), .err(res_err), .old_val(res_old)
    );

    rmw_store #(.DATA_W(DATA_W), .ROWS(ROWS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .row_idx(cur_addr[ADDR_W-1:1]),
        .wr_lo(exec && a_wr_lo), .wr_hi(exec && a_wr_hi),
        .wr_row(wr_row), .rd_row(cur_row)
    );
endmodule

// File: tb/atomic_rmw_unit_tb.sv
module atomic_rmw_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [2*DW-1:0] req_cmp = '0, req_new = '0;
    logic          rsp_valid, rsp_ok, rsp_err;
    logic [2*DW-1:0] rsp_old;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    logic          g_ok, g_err;
    logic [2*DW-1:0] g_old;

    atomic_rmw_unit #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_cmp(req_cmp), .req_new(req_new),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err), .rsp_old(rsp_old)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [2*DW-1:0] act, input logic [2*DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One request through the handshake; checks lock and latency (R9).
    task automatic do_op(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [2*DW-1:0] c, input logic [2*DW-1:0] n);
        @(negedge clk);
        chk("R9 ready idle", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1; req_op = op; req_addr = a; req_cmp = c; req_new = n;
        @(posedge clk); #1;
        chk("R9 ready low while locked", {63'd0, req_ready}, 64'd0);
        chk("R9 no early response", {63'd0, rsp_valid}, 64'd0);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        chk("R9 response at second edge", {63'd0, rsp_valid}, 64'd1);
        g_ok = rsp_ok; g_err = rsp_err; g_old = rsp_old;
    endtask

    task automatic rd_expect(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        do_op(3'd0, a, '0, '0);
        chk(tag, g_old, {32'd0, exp});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        chk("R1 ready after reset", {63'd0, req_ready}, 64'd1);
        @(negedge clk); rst_n = 1'b1;
        rd_expect("R1 memory zero", 6'd5, 32'd0);
    endtask

    task automatic t_read_write;
        do_op(3'd1, 6'd3, '0, 64'hFFFF_0000_AAAA_0003);
        chk("R2 write ok", {63'd0, g_ok}, 64'd1);
        chk("R2 write returns prior", g_old, 64'd0);
        do_op(3'd0, 6'd3, '0, '0);
        chk("R2 read value", g_old, 64'h0000_0000_AAAA_0003);
        chk("R10 flags not both", {62'd0, g_ok, g_err}, 64'd2);
    endtask

    task automatic t_cas_flag;
        do_op(3'd2, 6'd3, 64'hAAAA_0003, 64'h11);
        chk("R3 match ok", {63'd0, g_ok}, 64'd1);
        chk("R3 old zero", g_old, 64'd0);
        rd_expect("R3 swapped", 6'd3, 32'h11);
        do_op(3'd2, 6'd3, 64'h12, 64'h99);
        chk("R3 mismatch fails", {63'd0, g_ok}, 64'd0);
        rd_expect("R3 unchanged on mismatch", 6'd3, 32'h11);
    endtask

    task automatic t_cas_val;
        do_op(3'd3, 6'd3, 64'h0, 64'h5);
        chk("R4 mismatch fails", {63'd0, g_ok}, 64'd0);
        chk("R4 mismatch returns prior", g_old, 64'h11);
        rd_expect("R4 unchanged", 6'd3, 32'h11);
        do_op(3'd3, 6'd3, 64'h11, 64'h22);
        chk("R4 match ok", {63'd0, g_ok}, 64'd1);
        chk("R4 match returns prior", g_old, 64'h11);
        rd_expect("R4 swapped", 6'd3, 32'h22);
    endtask

    task automatic t_fadd;
        do_op(3'd1, 6'd7, '0, 64'hFFFF_FFFE);
        do_op(3'd4, 6'd7, '0, 64'h5);
        chk("R5 returns prior", g_old, 64'hFFFF_FFFE);
        chk("R5 ok", {63'd0, g_ok}, 64'd1);
        rd_expect("R5 wraps", 6'd7, 32'h3);
    endtask

    task automatic t_dcas;
        do_op(3'd1, 6'd8, '0, 64'h100);
        do_op(3'd1, 6'd9, '0, 64'h1);
        do_op(3'd5, 6'd8, 64'h0000_0001_0000_0100, 64'h0000_0002_0000_0200);
        chk("R6 match ok", {63'd0, g_ok}, 64'd1);
        chk("R6 old pair", g_old, 64'h0000_0001_0000_0100);
        rd_expect("R6 low word", 6'd8, 32'h200);
        rd_expect("R6 high word", 6'd9, 32'h2);
        do_op(3'd5, 6'd8, 64'h0000_0001_0000_0200, 64'h0000_0003_0000_0300);
        chk("R6 stale tag fails", {63'd0, g_ok}, 64'd0);
        chk("R6 stale tag old", g_old, 64'h0000_0002_0000_0200);
        do_op(3'd5, 6'd8, 64'h0000_0002_0000_0300, 64'h0000_0003_0000_0300);
        chk("R6 wrong pointer fails", {63'd0, g_ok}, 64'd0);
        rd_expect("R6 low kept", 6'd8, 32'h200);
        rd_expect("R6 high kept", 6'd9, 32'h2);
    endtask

    task automatic t_misaligned;
        do_op(3'd5, 6'd9, 64'h0000_0000_0000_0002, 64'h0000_0007_0000_0007);
        chk("R7 err", {62'd0, g_ok, g_err}, 64'd1);
        chk("R7 old zero", g_old, 64'd0);
        rd_expect("R7 word 9 kept", 6'd9, 32'h2);
        rd_expect("R7 word 10 kept", 6'd10, 32'h0);
        rd_expect("R7 word 8 kept", 6'd8, 32'h200);
    endtask

    task automatic t_bad_op;
        do_op(3'd6, 6'd3, 64'h22, 64'h77);
        chk("R8 op6 err", {62'd0, g_ok, g_err}, 64'd1);
        do_op(3'd7, 6'd3, 64'h22, 64'h77);
        chk("R8 op7 err", {62'd0, g_ok, g_err}, 64'd1);
        rd_expect("R8 unchanged", 6'd3, 32'h22);
    endtask

    initial begin
        t_reset;
        t_read_write;
        t_cas_flag;
        t_cas_val;
        t_fadd;
        t_dcas;
        t_misaligned;
        t_bad_op;
        repeat (2) @(posedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule